// File: doc/BRIEF.md
# ECC Guarded Memory Read Path

This block sits between a processor's tightly coupled memory port and a single-port SRAM. Each stored word carries single-error-correct, double-error-detect (SECDED) check bits. On a write, the block computes the check bits and stores the full codeword. On a read, it checks the codeword that comes back from the SRAM one cycle later. A clean word is returned to the processor directly. When an error is found, the block sends a one-cycle retry pulse instead of the response, and the processor then requests the same address again.

On that retried request, a correctable word is delivered already corrected, and the re-encoded codeword is written back to the SRAM in the same cycle the request is accepted. A word with two flipped bits is never delivered: the retried request gets an error response so that the processor can take a fault. Two saturating counters (corrected and uncorrectable events) and a last-fault address register are visible on sideband outputs and can be cleared by a pulse.

With 32 data bits, a codeword is 39 bits wide. The data sits in bits [DW-1:0]. The Hamming check bits sit above the data, and the overall parity bit is the most significant bit. Each data bit is mapped, in ascending order, onto the Hamming positions 3, 5, 6, 7, 9 and so on, skipping every power of two.

Top module: `ecc_mem_guard`

## Requirements
- R1: A read accepted at a clock edge (req_valid and req_ready both high) of an unmodified word gives rsp_valid high one cycle later, with rsp_rdata equal to the last data written, and with rsp_retry and rsp_err low.
- R2: A write stores a codeword whose bits [DW-1:0] equal the written data, with the check bits in [CW-2:DW] and the overall parity in bit CW-1.
- R3: A read of a word holding any detected error (one or two flipped bits) gives rsp_retry high for exactly one cycle in place of the response, with rsp_valid, rsp_err and req_ready low in that cycle.
- R4: After a single-bit error in any of the CW codeword bits (data, check or overall parity), the retried read of the same address returns the original data with rsp_valid high and rsp_err low.
- R5: In the cycle the retried read of a correctable word is accepted, the block writes the re-encoded corrected codeword to that address. Afterwards the SRAM holds the original codeword, and a later read of that address is clean.
- R6: After a double-bit error, the retried read of that address gives rsp_valid and rsp_err high with rsp_rdata zero, performs no SRAM write, and leaves the stored word unchanged. A held double-error record is dropped by any other request, which is not stalled.
- R7: While a correctable write-back is still pending, any request other than the retried read is stalled for exactly one cycle (req_ready low), during which the write-back to the faulty address is performed. The request is accepted in the next cycle.
- R8: stat_sec_cnt counts correctable detections and stat_ded_cnt counts uncorrectable detections. Each increments by one per detection and saturates at 2^CNT_W-1. The retried read served from the held record is not counted again.
- R9: stat_fault_addr holds the address of the most recent detected error of either kind.
- R10: A one-cycle stat_clr pulse sets both counters and stat_fault_addr to zero.
- R11: After reset, req_ready is high with no request pending, there is no response, and the counters and fault address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_retry | output | 1 | One-cycle pulse: repeat the read of the same address |
| rsp_err | output | 1 | Uncorrectable error; no data returned |
| rsp_rdata | output | DW | Read data |
| ram_en | output | 1 | SRAM access enable |
| ram_we | output | 1 | SRAM write enable |
| ram_addr | output | AW | SRAM address |
| ram_wdata | output | CW | Codeword to store |
| ram_rdata | input | CW | Codeword read, one cycle after the access |
| stat_clr | input | 1 | Clear the counters and the fault address |
| stat_sec_cnt | output | CNT_W | Corrected error count |
| stat_ded_cnt | output | CNT_W | Uncorrectable error count |
| stat_fault_addr | output | AW | Address of the latest detected error |

## Verification
The bench builds the block with DW=32, AW=4 and CNT_W=4: a full 39-bit codeword over a 16-word memory, with counters that saturate at 15. This small configuration allows an exhaustive sweep of every single-bit flip position, including the check and overall parity bits, and of all 741 two-bit flip pairs, each spread across the addresses. Both counters therefore reach and hold their saturation value during the sweeps. Directed sequences add the one-cycle write-back stall, the dropping of a held double-error record, and the clear pulse.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;

  typedef enum logic [1:0] {
    CHK_CLEAN = 2'd0,
    CHK_SEC   = 2'd1,
    CHK_DED   = 2'd2
  } chk_kind_e;

  // Number of Hamming check bits p such that 2^p >= dw + p + 1
  function automatic int hamming_bits(input int dw);
    int p;
    p = 1;
    for (int k = 0; k < 12; k++) begin
      if ((1 << p) < dw + p + 1) p = p + 1;
    end
    return p;
  endfunction

  // Hamming position of data bit j: the j-th index >= 3 that is not a power of two
  function automatic int data_slot(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int pos = 3; pos < 1024; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (cnt == j) res = pos;
        cnt = cnt + 1;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/secded_chkgen.sv
module secded_chkgen import ecc_guard_pkg::*; #(
  parameter int DW = 32,
  parameter int P  = 6
) (
  input  logic [DW-1:0] data,
  output logic [P-1:0]  chk
);

  logic [P-1:0] contrib [DW];

  for (genvar gj = 0; gj < DW; gj++) begin : g_slot
    localparam int SLOT = data_slot(gj);
    localparam logic [P-1:0] SLOT_V = SLOT[P-1:0];
    assign contrib[gj] = data[gj] ? SLOT_V : '0;
  end

  always_comb begin
    chk = '0;
    for (int j = 0; j < DW; j++) chk = chk ^ contrib[j];
  end

endmodule

// File: rtl/secded_check.sv
module secded_check import ecc_guard_pkg::*; #(
  parameter int DW = 32,
  parameter int P  = 6,
  parameter int CW = DW + P + 1
) (
  input  logic [CW-1:0] cw,
  output chk_kind_e     kind,
  output logic [DW-1:0] fixed
);

  logic [P-1:0] recalc;
  logic [P-1:0] syn;
  logic         par;

  secded_chkgen #(.DW(DW), .P(P)) u_gen (
    .data (cw[DW-1:0]),
    .chk  (recalc)
  );

  assign syn = cw[CW-2:DW] ^ recalc;
  assign par = ^cw;

  always_comb begin
    if (par)       kind = CHK_SEC;
    else if (|syn) kind = CHK_DED;
    else           kind = CHK_CLEAN;
  end

  // Flip the data bit whose Hamming slot matches the syndrome
  for (genvar gj = 0; gj < DW; gj++) begin : g_fix
    localparam int SLOT = data_slot(gj);
    localparam logic [P-1:0] SLOT_V = SLOT[P-1:0];
    assign fixed[gj] = cw[gj] ^ (par && (syn == SLOT_V));
  end

endmodule

// File: rtl/ecc_err_stats.sv
module ecc_err_stats #(
  parameter int AW    = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       ev,
  input  logic [AW-1:0]    ev_addr,
  output logic [CNT_W-1:0] sec_cnt,
  output logic [CNT_W-1:0] ded_cnt,
  output logic [AW-1:0]    last_addr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0][CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]         addr_q, addr_d;

  for (genvar g = 0; g < 2; g++) begin : g_ctr
    always_comb begin
      cnt_d[g] = cnt_q[g];
      if (clr)                                cnt_d[g] = '0;
      else if (ev[g] && (cnt_q[g] != CNT_MAX)) cnt_d[g] = cnt_q[g] + 1'b1;
    end
  end

  always_comb begin
    addr_d = addr_q;
    if (clr)      addr_d = '0;
    else if (|ev) addr_d = ev_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign sec_cnt   = cnt_q[0];
  assign ded_cnt   = cnt_q[1];
  assign last_addr = addr_q;

endmodule

// File: rtl/ecc_mem_guard.sv
module ecc_mem_guard import ecc_guard_pkg::*; #(
  parameter int DW    = 32,
  parameter int AW    = 10,
  parameter int CNT_W = 16,
  localparam int P    = hamming_bits(DW),
  localparam int CW   = DW + P + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic             rsp_retry,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             ram_en,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [CW-1:0]    ram_wdata,
  input  logic [CW-1:0]    ram_rdata,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] stat_sec_cnt,
  output logic [CNT_W-1:0] stat_ded_cnt,
  output logic [AW-1:0]    stat_fault_addr
);

  // Control state (reset)
  logic rd_pend_q, rd_pend_d;
  logic held_vld_q, held_vld_d;
  logic srv_pend_q, srv_pend_d;
  // Datapath state (loaded under enables)
  logic [AW-1:0] rd_addr_q;
  logic          held_ded_q;
  logic [AW-1:0] held_addr_q;
  logic [DW-1:0] held_data_q;
  logic          srv_err_q;
  logic [DW-1:0] srv_data_q;

  logic          acc, hit, scrub_now, det, clean;
  logic          rd_addr_en, held_ld, srv_ld;
  logic [P-1:0]  wr_chk, sc_chk;
  logic [CW-1:0] wr_cw, sc_cw;
  chk_kind_e     kind;
  logic [DW-1:0] fixed;

  secded_chkgen #(.DW(DW), .P(P)) u_wr_gen (.data(req_wdata),   .chk(wr_chk));
  secded_chkgen #(.DW(DW), .P(P)) u_sc_gen (.data(held_data_q), .chk(sc_chk));

  assign wr_cw = {^{wr_chk, req_wdata},   wr_chk, req_wdata};
  assign sc_cw = {^{sc_chk, held_data_q}, sc_chk, held_data_q};

  secded_check #(.DW(DW), .P(P), .CW(CW)) u_chk (
    .cw    (ram_rdata),
    .kind  (kind),
    .fixed (fixed)
  );

  // Request side
  assign hit       = held_vld_q && req_valid && !req_we && (req_addr == held_addr_q);
  assign scrub_now = held_vld_q && !held_ded_q && req_valid;
  assign req_ready = !rd_pend_q && !srv_pend_q && !(held_vld_q && !held_ded_q && !hit);
  assign acc       = req_valid && req_ready;

  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = req_addr;
    ram_wdata = wr_cw;
    if (scrub_now) begin
      ram_en    = 1'b1;
      ram_we    = 1'b1;
      ram_addr  = held_addr_q;
      ram_wdata = sc_cw;
    end else if (acc && !hit) begin
      ram_en = 1'b1;
      ram_we = req_we;
    end
  end

  // Response side
  assign clean     = (kind == CHK_CLEAN);
  assign det       = rd_pend_q && !clean;
  assign rsp_retry = det;
  assign rsp_valid = srv_pend_q || (rd_pend_q && clean);
  assign rsp_err   = srv_pend_q && srv_err_q;
  assign rsp_rdata = srv_pend_q ? srv_data_q :
                     (rd_pend_q && clean) ? ram_rdata[DW-1:0] : '0;

  // Next state
  always_comb begin
    rd_pend_d  = acc && !req_we && !hit;
    rd_addr_en = acc;
    srv_pend_d = acc && hit;
    srv_ld     = acc && hit;
    held_ld    = det;
    held_vld_d = held_vld_q;
    if (det)                                              held_vld_d = 1'b1;
    else if (held_vld_q && req_valid && (req_ready || scrub_now)) held_vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q  <= 1'b0;
      held_vld_q <= 1'b0;
      srv_pend_q <= 1'b0;
    end else begin
      rd_pend_q  <= rd_pend_d;
      held_vld_q <= held_vld_d;
      srv_pend_q <= srv_pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_addr_en) rd_addr_q <= req_addr;
    if (held_ld) begin
      held_ded_q  <= (kind == CHK_DED);
      held_addr_q <= rd_addr_q;
      held_data_q <= fixed;
    end
    if (srv_ld) begin
      srv_err_q  <= held_ded_q;
      srv_data_q <= held_ded_q ? '0 : held_data_q;
    end
  end

  ecc_err_stats #(.AW(AW), .CNT_W(CNT_W)) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (stat_clr),
    .ev        ({det && (kind == CHK_DED), det && (kind == CHK_SEC)}),
    .ev_addr   (rd_addr_q),
    .sec_cnt   (stat_sec_cnt),
    .ded_cnt   (stat_ded_cnt),
    .last_addr (stat_fault_addr)
  );

endmodule

// File: rtl/ecc_mem_guard_props.sv
module ecc_mem_guard_props #(
  parameter int DW    = 32,
  parameter int AW    = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_retry,
  input logic             rsp_err,
  input logic [DW-1:0]    rsp_rdata,
  input logic             ram_en,
  input logic             stat_clr,
  input logic [CNT_W-1:0] stat_sec_cnt,
  input logic [CNT_W-1:0] stat_ded_cnt
);

  // R3: retry is a single-cycle pulse
  a_r3_retry_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |=> !rsp_retry);

  // R3: retry stands alone: no data, no error, no acceptance, no SRAM access
  a_r3_retry_alone: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_retry |-> (!rsp_valid && !rsp_err && !req_ready && !ram_en));

  // R6: an error response carries no data
  a_r6_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));

  // R8: counters never decrease without a clear
  a_r8_sec_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> (stat_sec_cnt >= $past(stat_sec_cnt)));

  a_r8_ded_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> (stat_ded_cnt >= $past(stat_ded_cnt)));

  // R10: clear empties both counters
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (stat_sec_cnt == '0 && stat_ded_cnt == '0));

endmodule

bind ecc_mem_guard ecc_mem_guard_props #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_props (.*);

// File: tb/sim_ecc_mem_guard.sv
`timescale 1ns/1ps
module sim_ecc_mem_guard;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int CNT_W = 4;
  localparam int P     = ecc_guard_pkg::hamming_bits(DW);
  localparam int CW    = DW + P + 1;
  localparam int WORDS = 1 << AW;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk, rst_n;
  logic req_valid, req_ready, req_we;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid, rsp_retry, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [CW-1:0] ram_wdata, ram_rdata;
  logic stat_clr;
  logic [CNT_W-1:0] stat_sec_cnt, stat_ded_cnt;
  logic [AW-1:0] stat_fault_addr;

  int checks = 0;
  int errors = 0;

  ecc_mem_guard #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural SRAM, one-cycle read latency, plus a bit-flip injector
  logic [CW-1:0] mem  [WORDS];
  logic [CW-1:0] gold [WORDS];
  logic          inj_go;
  logic [AW-1:0] inj_addr;
  logic [CW-1:0] inj_mask;

  always @(posedge clk) begin
    if (inj_go) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    else if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata     <= mem[ram_addr];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Captured at the negedge before the accepting edge, and at the first stall
  int            stalls;
  logic          acc_en, acc_we, st_we;
  logic [AW-1:0] acc_addr, st_addr;
  logic [CW-1:0] acc_wdata;

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    stalls = 0; st_we = 1'b0; st_addr = '0;
    #1;
    while (!req_ready) begin
      if (stalls == 0) begin st_we = ram_en && ram_we; st_addr = ram_addr; end
      stalls++;
      @(negedge clk); #1;
    end
    acc_en = ram_en; acc_we = ram_we; acc_addr = ram_addr; acc_wdata = ram_wdata;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic [CW-1:0] m);
    @(negedge clk);
    inj_go = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk);
    inj_go = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [DW-1:0] v;
    v = DW'(32'h9E3779B9) * DW'(a + 1);
    return v ^ DW'(salt * 32'h01010101) ^ DW'(32'h5A00C3F0);
  endfunction

  int exp_sec = 0;
  int exp_ded = 0;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    stat_clr = 1'b0; inj_go = 1'b0; inj_addr = '0; inj_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R11 reset state
    check(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
    check(!rsp_valid && !rsp_retry && !rsp_err, "R11 no response",
          64'({rsp_valid, rsp_retry, rsp_err}), 64'd0);
    check(stat_sec_cnt == 0 && stat_ded_cnt == 0 && stat_fault_addr == 0, "R11 stats",
          64'({stat_sec_cnt, stat_ded_cnt, stat_fault_addr}), 64'd0);

    // R2 write layout, R1 clean reads
    for (int a = 0; a < WORDS; a++) begin
      issue(1'b1, AW'(a), pat(a, 0));
      gold[a] = mem[a];
      check(gold[a][DW-1:0] == pat(a, 0), "R2 data field", 64'(gold[a][DW-1:0]), 64'(pat(a, 0)));
    end
    for (int a = 0; a < WORDS; a++) begin
      issue(1'b0, AW'(a), '0);
      check(rsp_valid && !rsp_retry && !rsp_err, "R1 flags",
            64'({rsp_valid, rsp_retry, rsp_err}), 64'b100);
      check(rsp_rdata == pat(a, 0), "R1 data", 64'(rsp_rdata), 64'(pat(a, 0)));
    end

    // Single-bit sweep over every codeword position
    for (int pos = 0; pos < CW; pos++) begin
      int a;
      a = pos % WORDS;
      inject(AW'(a), CW'(1) << pos);
      issue(1'b0, AW'(a), '0);
      check(rsp_retry && !rsp_valid && !rsp_err, "R3 single retry",
            64'({rsp_retry, rsp_valid, rsp_err}), 64'b100);
      @(negedge clk); #1;
      check(!rsp_retry, "R3 retry one cycle", 64'(rsp_retry), 64'd0);
      issue(1'b0, AW'(a), '0);
      check(acc_en && acc_we && acc_addr == AW'(a) && acc_wdata == gold[a], "R5 write-back with forward",
            64'(acc_wdata), 64'(gold[a]));
      check(rsp_valid && !rsp_err && !rsp_retry && rsp_rdata == gold[a][DW-1:0], "R4 corrected data",
            64'(rsp_rdata), 64'(gold[a][DW-1:0]));
      check(mem[a] == gold[a], "R5 memory restored", 64'(mem[a]), 64'(gold[a]));
      if (exp_sec < CMAX) exp_sec++;
      check(int'(stat_sec_cnt) == exp_sec, "R8 sec count", 64'(stat_sec_cnt), 64'(exp_sec));
      check(stat_fault_addr == AW'(a), "R9 fault addr", 64'(stat_fault_addr), 64'(a));
      issue(1'b0, AW'(a), '0);
      check(rsp_valid && !rsp_retry, "R5 clean after scrub", 64'({rsp_valid, rsp_retry}), 64'b10);
    end

    // Double-bit sweep over all pairs
    for (int p = 0; p < CW; p++) begin
      for (int q = p + 1; q < CW; q++) begin
        int a;
        logic [CW-1:0] m;
        a = (p + q) % WORDS;
        m = (CW'(1) << p) | (CW'(1) << q);
        inject(AW'(a), m);
        issue(1'b0, AW'(a), '0);
        check(rsp_retry && !rsp_valid && !rsp_err, "R3 double retry",
              64'({rsp_retry, rsp_valid, rsp_err}), 64'b100);
        issue(1'b0, AW'(a), '0);
        check(!acc_en, "R6 no write-back", 64'(acc_en), 64'd0);
        check(rsp_valid && rsp_err && !rsp_retry && rsp_rdata == '0, "R6 error response",
              64'({rsp_valid, rsp_err, rsp_retry, rsp_rdata}), 64'({3'b110, DW'(0)}));
        check(mem[a] == (gold[a] ^ m), "R6 memory untouched", 64'(mem[a]), 64'(gold[a] ^ m));
        if (exp_ded < CMAX) exp_ded++;
        check(int'(stat_ded_cnt) == exp_ded, "R8 ded count", 64'(stat_ded_cnt), 64'(exp_ded));
        check(int'(stat_sec_cnt) == exp_sec, "R8 sec saturated", 64'(stat_sec_cnt), 64'(exp_sec));
        check(stat_fault_addr == AW'(a), "R9 fault addr double", 64'(stat_fault_addr), 64'(a));
        inject(AW'(a), m);
      end
    end

    // R10 clear
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0; #1;
    check(stat_sec_cnt == 0 && stat_ded_cnt == 0 && stat_fault_addr == 0, "R10 clear",
          64'({stat_sec_cnt, stat_ded_cnt, stat_fault_addr}), 64'd0);

    // R7 pending write-back stalls another request for one cycle
    inject(AW'(3), CW'(1) << 5);
    issue(1'b0, AW'(3), '0);
    check(rsp_retry, "R3 retry before stall", 64'(rsp_retry), 64'd1);
    issue(1'b1, AW'(9), pat(9, 7));
    check(stalls == 1, "R7 one stall cycle", 64'(stalls), 64'd1);
    check(st_we && st_addr == AW'(3), "R7 write-back during stall", 64'({st_we, st_addr}), 64'({1'b1, AW'(3)}));
    check(mem[3] == gold[3], "R7 memory restored", 64'(mem[3]), 64'(gold[3]));
    gold[9] = mem[9];
    issue(1'b0, AW'(9), '0);
    check(rsp_valid && rsp_rdata == pat(9, 7), "R7 stalled write landed", 64'(rsp_rdata), 64'(pat(9, 7)));
    issue(1'b0, AW'(3), '0);
    check(rsp_valid && !rsp_retry && rsp_rdata == gold[3][DW-1:0], "R7 scrubbed word clean",
          64'(rsp_rdata), 64'(gold[3][DW-1:0]));
    check(stat_sec_cnt == 1, "R8 count after clear", 64'(stat_sec_cnt), 64'd1);

    // R6 held double-error record dropped by another request, no stall
    inject(AW'(6), (CW'(1) << 0) | (CW'(1) << 38));
    issue(1'b0, AW'(6), '0);
    check(rsp_retry, "R6 retry", 64'(rsp_retry), 64'd1);
    issue(1'b0, AW'(7), '0);
    check(stalls == 0, "R6 no stall", 64'(stalls), 64'd0);
    check(rsp_valid && !rsp_err && rsp_rdata == gold[7][DW-1:0], "R6 other read", 64'(rsp_rdata), 64'(gold[7][DW-1:0]));
    inject(AW'(6), (CW'(1) << 0) | (CW'(1) << 38));
    issue(1'b0, AW'(6), '0);
    check(rsp_valid && !rsp_err && !rsp_retry && rsp_rdata == gold[6][DW-1:0], "R6 record dropped",
          64'(rsp_rdata), 64'(gold[6][DW-1:0]));
    check(stat_ded_cnt == 1 && stat_fault_addr == AW'(6), "R9 latest fault",
          64'({stat_ded_cnt, stat_fault_addr}), 64'({CNT_W'(1), AW'(6)}));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule